// File: doc/BRIEF.md
# DRAM Burst Column Order Generator

This block produces the column offset sequence that a DDR3-style memory device uses for one burst. A start pulse captures the low three column bits, the ordering mode, the read/write direction and the burst length selection. The block then steps through eight beat slots, one beat per clock of the beat-rate clock. On each slot it reports the column offset for that beat, whether the slot carries data, and whether the data and strobe drivers should be enabled or left in high impedance. For writes it also emits a one-cycle marker on the beat where internal write recovery timing (tWR/tWTR) begins.

Reads keep the burst inside the addressed half of the 8-word block, using either sequential wrap-around or XOR-interleaved order. Writes ignore the low start bits. A chopped burst of four keeps its full eight-slot footprint, but the last four slots carry no data. The write recovery marker moves four beats (two memory clocks) earlier only when chop-4 is fixed by the mode setting. It does not move when chop is chosen per command.

Top module: `burst_col_gen`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, and after it is released, slot_active, data_valid, drv_en and wr_rec_start are 0 and beat_idx is 0 until a start is accepted. A reset during a burst aborts that burst.
- R2: With burst_type=0 (sequential), a read places bit 2 of col_off at start_col[2] XOR beat_idx[2], and bits 1:0 at (start_col[1:0] + beat_idx[1:0]) mod 4. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R3: With burst_type=1 (interleaved), a read outputs col_off = start_col XOR beat_idx. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R4: A write with an 8-beat burst outputs col_off = beat_idx (0..7), whatever start_col and burst_type are.
- R5: A chop-4 write ignores start_col[1:0]. It outputs col_off = {start_col[2],2'b00} XOR beat_idx, so beats 0..3 are 0,1,2,3 or 4,5,6,7.
- R6: In a chop-4 burst, data_valid is 1 only on beats 0..3. In an 8-beat burst it is 1 on all eight beats.
- R7: drv_en is 1 exactly on read beats that carry data. It is 0 on every write beat, on the tail of a chopped read, and while idle.
- R8: Each write burst raises wr_rec_start for exactly one cycle. This happens at beat 7 for an 8-beat burst or a per-command chop, and at beat 3 when chop is fixed by bl_mode. Reads never raise it.
- R9: bl_mode is encoded as follows: 00 = fixed 8, 01 = fixed chop-4, 10 = per command (otf_chop=1 chops), 11 = treated as fixed 8. otf_chop has no effect unless bl_mode is 10.
- R10: A start is accepted when the block is idle or on beat 7. Beat 0 appears in the cycle after the accepting edge, beat_idx then counts 0..7 on consecutive cycles with slot_active high, and without a new start the block is idle in the following cycle.
- R11: A start seen during beats 0..6 is ignored. The running burst keeps its captured settings and ends on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for a new burst |
| start_col | input | 3 | Low column bits of the burst start |
| burst_type | input | 1 | 0 = sequential, 1 = interleaved |
| is_read | input | 1 | 1 = read burst, 0 = write burst |
| bl_mode | input | 2 | Burst length selection (see R9) |
| otf_chop | input | 1 | Per-command chop select, used when bl_mode = 10 |
| slot_active | output | 1 | A burst slot is in progress |
| beat_idx | output | 3 | Beat slot index 0..7 |
| col_off | output | 3 | Column offset for this beat |
| data_valid | output | 1 | This slot carries data |
| drv_en | output | 1 | Data and strobe drivers enabled (0 = high impedance) |
| wr_rec_start | output | 1 | Write recovery timing begins on this beat |

## Verification
Some properties are checked on every cycle: the quiet outputs while idle, the beat count stepping, the hold of captured settings during a burst, and the step-to-step shape of both read orders. The checker also tests the absence of driving on writes and chopped tails, the identity order of 8-beat writes, and that the recovery marker belongs only to writes. Only the bench's scenarios can show the exact offset values for every start, order, direction and length combination. The same applies to the beat on which the recovery marker lands, the handling of the reserved length code and of otf_chop outside per-command mode, and the rejection of a mid-burst start followed by a seamless one on beat 7.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    // Column offset width; a burst walks every offset of an aligned block.
    localparam int OFF_W       = 3;
    localparam int BURST_BEATS = 1 << OFF_W;
    localparam int HALF_BEATS  = BURST_BEATS / 2;

    typedef enum logic [1:0] {
        BL_FIXED8     = 2'b00,
        BL_FIXED_CHOP = 2'b01,
        BL_PER_CMD    = 2'b10,
        BL_RESERVED   = 2'b11
    } bl_mode_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } ord_e;

    typedef struct packed {
        logic             rd;
        ord_e             ord;
        logic             chop;
        logic             chop_fixed;
        logic [OFF_W-1:0] base;
    } burst_cfg_t;

    // Chop-4 selected either by mode or per command.
    function automatic logic resolve_chop(input bl_mode_e mode, input logic otf);
        return (mode == BL_FIXED_CHOP) || ((mode == BL_PER_CMD) && otf);
    endfunction

    // Start offset after direction-dependent masking.
    function automatic logic [OFF_W-1:0] effective_base(input logic rd,
                                                        input logic chop,
                                                        input logic [OFF_W-1:0] start);
        logic [OFF_W-1:0] b;
        if (rd)
            b = start;
        else if (chop)
            b = {start[OFF_W-1], {(OFF_W-1){1'b0}}};
        else
            b = '0;
        return b;
    endfunction

    // Sequential: wrap within the half, then switch half.
    function automatic logic [OFF_W-1:0] seq_offset(input logic [OFF_W-1:0] base,
                                                    input logic [OFF_W-1:0] beat);
        logic [OFF_W-2:0] low;
        low = base[OFF_W-2:0] + beat[OFF_W-2:0];
        return {base[OFF_W-1] ^ beat[OFF_W-1], low};
    endfunction

    // Interleaved: bitwise XOR of start and beat.
    function automatic logic [OFF_W-1:0] intlv_offset(input logic [OFF_W-1:0] base,
                                                      input logic [OFF_W-1:0] beat);
        return base ^ beat;
    endfunction

endpackage

// File: rtl/bcg_cfg_latch.sv
module bcg_cfg_latch
    import burst_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OFF_W-1:0] start_col,
    input  logic             burst_type,
    input  logic             is_read,
    input  logic [1:0]       bl_mode,
    input  logic             otf_chop,
    output burst_cfg_t       cfg_q
);

    burst_cfg_t cfg_d;
    bl_mode_e   mode;

    always_comb begin
        mode             = bl_mode_e'(bl_mode);
        cfg_d.rd         = is_read;
        cfg_d.ord        = ord_e'(burst_type);
        cfg_d.chop       = resolve_chop(mode, otf_chop);
        cfg_d.chop_fixed = (mode == BL_FIXED_CHOP);
        cfg_d.base       = effective_base(is_read, cfg_d.chop, start_col);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_d;
    end

endmodule

// File: rtl/bcg_beat_seq.sv
module bcg_beat_seq #(
    parameter int BEATS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    output logic                     active,
    output logic [$clog2(BEATS)-1:0] beat,
    output logic                     last
);

    localparam int BW = $clog2(BEATS);
    localparam logic [BW-1:0] LAST_IDX = BW'(BEATS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (load) begin
            active <= 1'b1;
            beat   <= '0;
        end else if (active) begin
            if (beat == LAST_IDX) begin
                active <= 1'b0;
                beat   <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    assign last = active && (beat == LAST_IDX);

endmodule

// File: rtl/bcg_order.sv
module bcg_order
    import burst_col_pkg::*;
(
    input  logic             rd,
    input  ord_e             ord,
    input  logic [OFF_W-1:0] base,
    input  logic [OFF_W-1:0] beat,
    output logic [OFF_W-1:0] col
);

    always_comb begin
        if (!rd)
            col = intlv_offset(base, beat);   // base already masked for writes
        else if (ord == ORD_INTLV)
            col = intlv_offset(base, beat);
        else
            col = seq_offset(base, beat);
    end

endmodule

// File: rtl/bcg_flags.sv
module bcg_flags
    import burst_col_pkg::*;
#(
    parameter int BEATS_PER_CLK = 2,
    parameter int WR_PULL_CLKS  = 2
) (
    input  logic             active,
    input  logic             rd,
    input  logic             chop,
    input  logic             chop_fixed,
    input  logic [OFF_W-1:0] beat,
    output logic             data_valid,
    output logic             drv_en,
    output logic             wr_rec
);

    localparam int PULL_BEATS = BEATS_PER_CLK * WR_PULL_CLKS;
    localparam logic [OFF_W-1:0] CHOP_LIM = OFF_W'(HALF_BEATS);
    localparam logic [OFF_W-1:0] REC_FULL = OFF_W'(BURST_BEATS - 1);
    localparam logic [OFF_W-1:0] REC_CHOP = OFF_W'(BURST_BEATS - 1 - PULL_BEATS);

    logic [OFF_W-1:0] rec_beat;

    always_comb begin
        rec_beat   = chop_fixed ? REC_CHOP : REC_FULL;
        data_valid = active && (!chop || (beat < CHOP_LIM));
        drv_en     = data_valid && rd;
        wr_rec     = active && !rd && (beat == rec_beat);
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int BEATS_PER_CLK = 2,
    parameter int WR_PULL_CLKS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OFF_W-1:0] start_col,
    input  logic             burst_type,
    input  logic             is_read,
    input  logic [1:0]       bl_mode,
    input  logic             otf_chop,
    output logic             slot_active,
    output logic [OFF_W-1:0] beat_idx,
    output logic [OFF_W-1:0] col_off,
    output logic             data_valid,
    output logic             drv_en,
    output logic             wr_rec_start
);

    burst_cfg_t cfg_q;
    logic       beat_last;
    logic       load;

    assign load = start && (!slot_active || beat_last);

    bcg_cfg_latch u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .start_col  (start_col),
        .burst_type (burst_type),
        .is_read    (is_read),
        .bl_mode    (bl_mode),
        .otf_chop   (otf_chop),
        .cfg_q      (cfg_q)
    );

    bcg_beat_seq #(.BEATS(BURST_BEATS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .active (slot_active),
        .beat   (beat_idx),
        .last   (beat_last)
    );

    bcg_order u_ord (
        .rd   (cfg_q.rd),
        .ord  (cfg_q.ord),
        .base (cfg_q.base),
        .beat (beat_idx),
        .col  (col_off)
    );

    bcg_flags #(
        .BEATS_PER_CLK (BEATS_PER_CLK),
        .WR_PULL_CLKS  (WR_PULL_CLKS)
    ) u_flags (
        .active     (slot_active),
        .rd         (cfg_q.rd),
        .chop       (cfg_q.chop),
        .chop_fixed (cfg_q.chop_fixed),
        .beat       (beat_idx),
        .data_valid (data_valid),
        .drv_en     (drv_en),
        .wr_rec     (wr_rec_start)
    );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk
    import burst_col_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             slot_active,
    input logic [OFF_W-1:0] beat_idx,
    input logic [OFF_W-1:0] col_off,
    input logic             data_valid,
    input logic             drv_en,
    input logic             wr_rec_start,
    input burst_cfg_t       cfg
);

    localparam logic [OFF_W-1:0] LAST_B = OFF_W'(BURST_BEATS - 1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !slot_active |-> (!data_valid && !drv_en && !wr_rec_start));

    assert_seq_first_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_active && cfg.rd && cfg.ord == ORD_SEQ && beat_idx == '0) |-> (col_off == cfg.base));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_active && cfg.rd && cfg.ord == ORD_SEQ && beat_idx[1:0] != 2'd3)
        |=> (col_off[1:0] == 2'($past(col_off[1:0]) + 2'd1)) && (col_off[2] == $past(col_off[2])));

    assert_intlv_step_R3: assert property (@(posedge clk) disable iff (rst)
        (slot_active && cfg.rd && cfg.ord == ORD_INTLV && beat_idx != LAST_B)
        |=> ((col_off ^ $past(col_off)) == (beat_idx ^ $past(beat_idx))));

    assert_wr8_identity_R4: assert property (@(posedge clk) disable iff (rst)
        (slot_active && !cfg.rd && !cfg.chop) |-> (col_off == beat_idx));

    assert_chop_tail_R6: assert property (@(posedge clk) disable iff (rst)
        (slot_active && cfg.chop && beat_idx[2]) |-> (!data_valid && !drv_en));

    assert_write_undriven_R7: assert property (@(posedge clk) disable iff (rst)
        (slot_active && !cfg.rd) |-> !drv_en);

    assert_rec_write_only_R8: assert property (@(posedge clk) disable iff (rst)
        wr_rec_start |-> (slot_active && !cfg.rd));

    assert_start_beat0_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !slot_active) |=> (slot_active && beat_idx == '0));

    assert_beat_step_R10: assert property (@(posedge clk) disable iff (rst)
        (slot_active && beat_idx != LAST_B) |=> (slot_active && beat_idx == 3'($past(beat_idx) + 3'd1)));

    assert_cfg_held_R11: assert property (@(posedge clk) disable iff (rst)
        (slot_active && beat_idx != LAST_B) |=> $stable(cfg));

endmodule

bind burst_col_gen burst_col_gen_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .slot_active  (slot_active),
    .beat_idx     (beat_idx),
    .col_off      (col_off),
    .data_valid   (data_valid),
    .drv_en       (drv_en),
    .wr_rec_start (wr_rec_start),
    .cfg          (cfg_q)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] start_col = '0;
    logic       burst_type = 1'b0;
    logic       is_read = 1'b0;
    logic [1:0] bl_mode = '0;
    logic       otf_chop = 1'b0;
    logic       slot_active;
    logic [2:0] beat_idx;
    logic [2:0] col_off;
    logic       data_valid;
    logic       drv_en;
    logic       wr_rec_start;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    burst_col_gen uut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_col    (start_col),
        .burst_type   (burst_type),
        .is_read      (is_read),
        .bl_mode      (bl_mode),
        .otf_chop     (otf_chop),
        .slot_active  (slot_active),
        .beat_idx     (beat_idx),
        .col_off      (col_off),
        .data_valid   (data_valid),
        .drv_en       (drv_en),
        .wr_rec_start (wr_rec_start)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int rd, input int typ, input int mode, input int otf, input int s);
        is_read    = rd[0];
        burst_type = typ[0];
        bl_mode    = mode[1:0];
        otf_chop   = otf[0];
        start_col  = s[2:0];
    endtask

    task automatic launch(input int rd, input int typ, input int mode, input int otf, input int s);
        @(negedge clk);
        set_cfg(rd, typ, mode, otf, s);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    function automatic int exp_col(input int rd, input int typ, input int chop, input int s, input int b);
        if (rd != 0) begin
            if (typ != 0) return s ^ b;
            return ((s & 4) ^ (b & 4)) | ((s + b) & 3);
        end
        if (chop != 0) return (s & 4) ^ b;
        return b;
    endfunction

    // Checks one beat slot already on the outputs (called at a negedge).
    task automatic check_beat(input int rd, input int typ, input int mode, input int otf,
                              input int s, input int b);
        int chop;
        int fixedc;
        int vld;
        string ctag;
        string vtag;
        chop   = ((mode == 1) || (mode == 2 && otf != 0)) ? 1 : 0;
        fixedc = (mode == 1) ? 1 : 0;
        vld    = (chop == 0 || b < 4) ? 1 : 0;
        if (rd != 0) ctag = (typ != 0) ? "R3" : "R2";
        else         ctag = (chop != 0) ? "R5" : "R4";
        vtag = (mode >= 2) ? "R9" : "R6";
        chk("R10", "slot_active", int'(slot_active), 1);
        chk("R10", "beat_idx", int'(beat_idx), b);
        chk(ctag, "col_off", int'(col_off), exp_col(rd, typ, chop, s, b));
        chk(vtag, "data_valid", int'(data_valid), vld);
        chk("R7", "drv_en", int'(drv_en), (vld != 0 && rd != 0) ? 1 : 0);
        chk("R8", "wr_rec_start", int'(wr_rec_start),
            (rd == 0 && b == ((fixedc != 0) ? 3 : 7)) ? 1 : 0);
    endtask

    task automatic check_idle(input string req);
        chk(req, "slot_active idle", int'(slot_active), 0);
        chk(req, "data_valid idle", int'(data_valid), 0);
        chk(req, "drv_en idle", int'(drv_en), 0);
        chk(req, "wr_rec_start idle", int'(wr_rec_start), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        chk("R1", "beat_idx in reset", int'(beat_idx), 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        // Full sweep: direction, order, length mode, per-command chop, start.
        for (int rd = 0; rd < 2; rd++)
            for (int typ = 0; typ < 2; typ++)
                for (int mode = 0; mode < 4; mode++)
                    for (int otf = 0; otf < 2; otf++)
                        for (int s = 0; s < 8; s++) begin
                            launch(rd, typ, mode, otf, s);
                            for (int b = 0; b < 8; b++) begin
                                @(negedge clk);
                                check_beat(rd, typ, mode, otf, s, b);
                            end
                        end
        @(negedge clk);
        check_idle("R10");

        // R11: start during beats 0..6 is ignored.
        launch(1, 0, 0, 0, 5);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            if (b == 2) begin
                set_cfg(0, 1, 1, 1, 2);
                start = 1'b1;
            end
            if (b == 3) start = 1'b0;
            check_beat(1, 0, 0, 0, 5, b);
            chk("R11", "col_off while foreign start", int'(col_off),
                exp_col(1, 0, 0, 5, b));
        end
        @(negedge clk);
        check_idle("R11");

        // R10: seamless start on beat 7.
        launch(0, 0, 0, 0, 3);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            check_beat(0, 0, 0, 0, 3, b);
        end
        set_cfg(1, 1, 2, 1, 6);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            check_beat(1, 1, 2, 1, 6, b);
        end
        @(negedge clk);
        check_idle("R10");

        // R1: reset in the middle of a burst.
        launch(1, 0, 0, 0, 1);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1");
        chk("R1", "beat_idx after reset", int'(beat_idx), 0);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule